// File: doc/BRIEF.md
# Passenger Door Open/Close Sequencer

This block drives the panel motor of one passenger door. Driver requests arrive as an external open pulse or level, an internal open level, an open-authorisation level and a close level. A combinational front end merges them into one open demand and one close demand. The close demand always wins over the open demand.

A state machine turns those demands and the door position sensors into three panel commands: enable, direction and speed. Opening runs fast. Closing runs slow, and it starts only after a warning phase. During that phase a chime output sounds for one second, counted in clock cycles.

An open demand during the warning phase cancels it. A close demand during opening stops the panels and starts the warning phase. An open demand during closing reverses the door. Closing ends in a locked rest state when the locked sensor is active, and otherwise in a closed rest state when the closed sensor is active. All panel commands are low in every rest state and while reset is asserted.

Top module: `door_seq_top`

## Requirements
- R1: The open demand is high exactly when (open_ext_i OR open_int_i) AND open_auth_i AND NOT close_req_i. From a closed or locked rest state, a high open demand starts opening on the next clock edge. Without authorisation the outputs stay 0.
- R2: While close_req_i is high, no open request starts or resumes opening.
- R3: While opening, the outputs are panel_en_o=1, panel_dir_o=1 (1 = opening direction), panel_speed_o=1 (1 = fast) and chime_o=0.
- R4: A close demand from the open rest state starts a warning phase. During that phase chime_o=1 and all panel commands are 0 for exactly CLK_PER_SEC*WARN_SEC cycles. After that, closing drives panel_en_o=1, panel_dir_o=0, panel_speed_o=0 and chime_o=0.
- R5: Opening stops when sns_open_i is high at a clock edge. The door then enters the open rest state, where all outputs are 0.
- R6: A close demand during opening stops the panels and enters the warning phase on the next clock edge.
- R7: An open demand during the warning phase cancels it. The block returns to opening on the next clock edge, and chime_o drops.
- R8: Closing ends on a clock edge at which sns_locked_i or sns_closed_i is high. All outputs are then 0, and a later open demand starts opening again.
- R9: An open demand during closing reverses the door into opening on the next clock edge.
- R10: The approach sensors sns_appr_open_i and sns_appr_closed_i have no effect on any output.
- R11: While rst_ni is low, all outputs are 0, immediately and asynchronously.
- R12: A close demand in a closed rest state does not sound the chime and does not move the panels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_ext_i | input | 1 | Open request from outside the car |
| open_int_i | input | 1 | Open request from inside the car |
| open_auth_i | input | 1 | Opening authorised level |
| close_req_i | input | 1 | Close request level, overrides open |
| sns_open_i | input | 1 | Door fully open sensor |
| sns_closed_i | input | 1 | Door fully closed sensor |
| sns_appr_open_i | input | 1 | Door approaching open sensor |
| sns_appr_closed_i | input | 1 | Door approaching closed sensor |
| sns_locked_i | input | 1 | Door closed and locked sensor |
| panel_en_o | output | 1 | Panel motor enable |
| panel_dir_o | output | 1 | Panel direction, 1 = opening |
| panel_speed_o | output | 1 | Panel speed, 1 = fast |
| chime_o | output | 1 | Warning chime active |

## Verification
The bench builds the block with CLK_PER_SEC = 6 and WARN_SEC = 1, so the warning phase lasts six cycles. At that length a table walk can cover the whole warning phase and the first closing cycle several times: full closes, a cancelled warning, a reversal during closing and the locked ending. With the short window, the bench can check the exact cycle in which the closing command appears. A bound checker counts the chime length at the start of every closing motion against the derived cycle count.

// File: rtl/door_seq_pkg.sv
package door_seq_pkg;

  typedef enum logic [2:0] {
    ST_SHUT    = 3'd0,
    ST_RISING  = 3'd1,
    ST_HELD    = 3'd2,
    ST_CHIME   = 3'd3,
    ST_FALLING = 3'd4,
    ST_BOLTED  = 3'd5
  } door_state_e;

  typedef struct packed {
    logic en;
    logic dir;
    logic speed;
    logic chime;
  } panel_cmd_t;

  localparam panel_cmd_t CMD_IDLE  = '{en: 1'b0, dir: 1'b0, speed: 1'b0, chime: 1'b0};
  localparam panel_cmd_t CMD_OPEN  = '{en: 1'b1, dir: 1'b1, speed: 1'b1, chime: 1'b0};
  localparam panel_cmd_t CMD_CLOSE = '{en: 1'b1, dir: 1'b0, speed: 1'b0, chime: 1'b0};
  localparam panel_cmd_t CMD_WARN  = '{en: 1'b0, dir: 1'b0, speed: 1'b0, chime: 1'b1};

endpackage

// File: rtl/door_req_qual.sv
module door_req_qual (
  input  logic open_ext_i,
  input  logic open_int_i,
  input  logic open_auth_i,
  input  logic close_req_i,
  output logic open_dmd_o,
  output logic close_dmd_o
);

  always_comb begin
    close_dmd_o = close_req_i;
    open_dmd_o  = (open_ext_i | open_int_i) & open_auth_i & ~close_req_i;
  end

endmodule

// File: rtl/door_warn_timer.sv
module door_warn_timer #(
  parameter int unsigned WARN_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CNT_W = (WARN_CYC > 1) ? $clog2(WARN_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (!done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/door_fsm.sv
module door_fsm
  import door_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        open_dmd_i,
  input  logic        close_dmd_i,
  input  logic        sns_open_i,
  input  logic        sns_closed_i,
  input  logic        sns_locked_i,
  input  logic        warn_done_i,
  output door_state_e state_o
);

  door_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SHUT, ST_BOLTED: begin
        if (open_dmd_i) state_d = ST_RISING;
      end
      ST_RISING: begin
        // close has priority over reaching the end stop
        if (close_dmd_i)     state_d = ST_CHIME;
        else if (sns_open_i) state_d = ST_HELD;
      end
      ST_HELD: begin
        if (close_dmd_i) state_d = ST_CHIME;
      end
      ST_CHIME: begin
        if (open_dmd_i)       state_d = ST_RISING;
        else if (warn_done_i) state_d = ST_FALLING;
      end
      ST_FALLING: begin
        if (open_dmd_i)        state_d = ST_RISING;
        else if (sns_locked_i) state_d = ST_BOLTED;
        else if (sns_closed_i) state_d = ST_SHUT;
      end
      default: state_d = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SHUT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/door_cmd_dec.sv
module door_cmd_dec
  import door_seq_pkg::*;
(
  input  door_state_e state_i,
  output panel_cmd_t  cmd_o
);

  always_comb begin
    unique case (state_i)
      ST_RISING:  cmd_o = CMD_OPEN;
      ST_CHIME:   cmd_o = CMD_WARN;
      ST_FALLING: cmd_o = CMD_CLOSE;
      default:    cmd_o = CMD_IDLE;
    endcase
  end

endmodule

// File: rtl/door_seq_top.sv
module door_seq_top
  import door_seq_pkg::*;
#(
  parameter int unsigned CLK_PER_SEC = 50_000_000,
  parameter int unsigned WARN_SEC    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_ext_i,
  input  logic open_int_i,
  input  logic open_auth_i,
  input  logic close_req_i,
  input  logic sns_open_i,
  input  logic sns_closed_i,
  input  logic sns_appr_open_i,
  input  logic sns_appr_closed_i,
  input  logic sns_locked_i,
  output logic panel_en_o,
  output logic panel_dir_o,
  output logic panel_speed_o,
  output logic chime_o
);

  localparam int unsigned WARN_CYC = CLK_PER_SEC * WARN_SEC;

  logic        open_dmd, close_dmd, warn_done;
  door_state_e state;
  panel_cmd_t  cmd;

  // approach sensors carry no control meaning here
  logic unused_appr;
  assign unused_appr = sns_appr_open_i ^ sns_appr_closed_i;

  door_req_qual i_qual (
    .open_ext_i  (open_ext_i),
    .open_int_i  (open_int_i),
    .open_auth_i (open_auth_i),
    .close_req_i (close_req_i),
    .open_dmd_o  (open_dmd),
    .close_dmd_o (close_dmd)
  );

  door_warn_timer #(.WARN_CYC(WARN_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_CHIME),
    .done_o (warn_done)
  );

  door_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .open_dmd_i   (open_dmd),
    .close_dmd_i  (close_dmd),
    .sns_open_i   (sns_open_i),
    .sns_closed_i (sns_closed_i),
    .sns_locked_i (sns_locked_i),
    .warn_done_i  (warn_done),
    .state_o      (state)
  );

  door_cmd_dec i_dec (
    .state_i (state),
    .cmd_o   (cmd)
  );

  assign panel_en_o    = cmd.en;
  assign panel_dir_o   = cmd.dir;
  assign panel_speed_o = cmd.speed;
  assign chime_o       = cmd.chime;

endmodule

// File: rtl/door_seq_chk.sv
module door_seq_chk #(
  parameter int unsigned WARN_CYC = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic open_ext_i,
  input logic open_int_i,
  input logic open_auth_i,
  input logic close_req_i,
  input logic panel_en_o,
  input logic panel_dir_o,
  input logic panel_speed_o,
  input logic chime_o
);

  localparam int unsigned RUN_W = $clog2(WARN_CYC + 2);

  logic             opening, closing;
  logic [RUN_W-1:0] chime_run_q;

  assign opening = panel_en_o &&  panel_dir_o;
  assign closing = panel_en_o && !panel_dir_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chime_run_q <= '0;
    else if (chime_o) chime_run_q <= chime_run_q + 1'b1;
    else              chime_run_q <= '0;
  end

  // R3
  open_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opening |-> (panel_speed_o && !chime_o));

  // R4
  close_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    closing |-> (!panel_speed_o && !chime_o));

  // R4
  chime_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chime_o |-> !panel_en_o);

  // R4
  warn_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closing && !$past(closing)) |-> (chime_run_q == RUN_W'(WARN_CYC)));

  // R1
  open_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opening && !$past(opening)) |->
      $past((open_ext_i || open_int_i) && open_auth_i && !close_req_i));

  // R6
  close_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opening && close_req_i) |=> (chime_o && !panel_en_o));

endmodule

bind door_seq_top door_seq_chk #(.WARN_CYC(WARN_CYC)) i_door_seq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .open_ext_i    (open_ext_i),
  .open_int_i    (open_int_i),
  .open_auth_i   (open_auth_i),
  .close_req_i   (close_req_i),
  .panel_en_o    (panel_en_o),
  .panel_dir_o   (panel_dir_o),
  .panel_speed_o (panel_speed_o),
  .chime_o       (chime_o)
);

// File: tb/test_door_seq_top.sv
module test_door_seq_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 39;

  // {ext,int,auth,close,s_open,s_closed,s_appr_open,s_appr_closed,s_locked}, {en,dir,speed,chime}
  localparam logic [12:0] VEC [NVEC] = '{
    {9'b100000000, 4'b0000}, // 0  R1 no auth
    {9'b101100000, 4'b0000}, // 1  R2 close masks open
    {9'b011000000, 4'b1110}, // 2  R1 R3 open
    {9'b000000100, 4'b1110}, // 3  R10 appr open
    {9'b000010000, 4'b0000}, // 4  R5 end stop
    {9'b000010000, 4'b0000}, // 5  R5 held
    {9'b000110000, 4'b0001}, // 6  R4 warn 1
    {9'b000000000, 4'b0001}, // 7  R4 warn 2
    {9'b000000010, 4'b0001}, // 8  R10 appr closed
    {9'b000000000, 4'b0001}, // 9
    {9'b000000000, 4'b0001}, // 10
    {9'b000000000, 4'b0001}, // 11 warn 6
    {9'b000000000, 4'b1000}, // 12 R4 closing
    {9'b000000010, 4'b1000}, // 13 R10
    {9'b000001000, 4'b0000}, // 14 R8 closed
    {9'b000100000, 4'b0000}, // 15 R12
    {9'b101000000, 4'b1110}, // 16 open
    {9'b000100000, 4'b0001}, // 17 R6
    {9'b000000000, 4'b0001}, // 18
    {9'b101000000, 4'b1110}, // 19 R7 cancel
    {9'b000010000, 4'b0000}, // 20
    {9'b000100000, 4'b0001}, // 21 R4
    {9'b000000000, 4'b0001}, // 22
    {9'b000000000, 4'b0001}, // 23
    {9'b000000000, 4'b0001}, // 24
    {9'b000000000, 4'b0001}, // 25
    {9'b000000000, 4'b0001}, // 26
    {9'b000000000, 4'b1000}, // 27 R4
    {9'b011000000, 4'b1110}, // 28 R9 reverse
    {9'b000100000, 4'b0001}, // 29 R6
    {9'b000000000, 4'b0001}, // 30
    {9'b000000000, 4'b0001}, // 31
    {9'b000000000, 4'b0001}, // 32
    {9'b000000000, 4'b0001}, // 33
    {9'b000000000, 4'b0001}, // 34
    {9'b000000000, 4'b1000}, // 35
    {9'b000001001, 4'b0000}, // 36 R8 locked
    {9'b000000001, 4'b0000}, // 37 R8
    {9'b101000000, 4'b1110}  // 38 R8 reopen from locked
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic open_ext, open_int, open_auth, close_req;
  logic s_open, s_closed, s_ao, s_ac, s_lock;
  logic en, dir, spd, chime;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  door_seq_top #(.CLK_PER_SEC(6), .WARN_SEC(1)) i_door_seq_top (
    .clk_i             (clk),
    .rst_ni            (rst_ni),
    .open_ext_i        (open_ext),
    .open_int_i        (open_int),
    .open_auth_i       (open_auth),
    .close_req_i       (close_req),
    .sns_open_i        (s_open),
    .sns_closed_i      (s_closed),
    .sns_appr_open_i   (s_ao),
    .sns_appr_closed_i (s_ac),
    .sns_locked_i      (s_lock),
    .panel_en_o        (en),
    .panel_dir_o       (dir),
    .panel_speed_o     (spd),
    .chime_o           (chime)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_chk++;
    if ({en, dir, spd, chime} !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {en,dir,spd,chime} = %b, expected %b", req, {en, dir, spd, chime}, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    {open_ext, open_int, open_auth, close_req, s_open, s_closed, s_ao, s_ac, s_lock} = v;
  endtask

  initial begin
    drive('0);
    #(CLK_PERIOD * 2);
    check("R11 reset state", 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    check("R11 after release", 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][12:4]);
      @(posedge clk);
      #(CLK_PERIOD / 4);
      check($sformatf("R1-table vector %0d", i), VEC[i][3:0]);
    end

    // R11 asynchronous reset while opening
    @(negedge clk);
    drive('0);
    #(CLK_PERIOD / 4);
    rst_ni = 1'b0;
    #1;
    check("R11 async reset during opening", 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    check("R11 idle after reset", 4'b0000);

    // R10 approach sensors alone in closed state
    @(negedge clk);
    drive(9'b000000110);
    @(posedge clk);
    #(CLK_PERIOD / 4);
    check("R10 approach sensors in closed state", 4'b0000);

    // R2 close held with both opens and authorisation
    @(negedge clk);
    drive(9'b111100000);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    check("R2 close overrides open", 4'b0000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule